// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs read and write management transactions toward an Ethernet PHY over the two-wire serial management interface. It makes the management clock by dividing the system clock with a programmable half-period. It drives the data line through a separate output and output-enable pair, and it reads the line back through an input. A host pulses a start request and gives a read or write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block answers with busy, a one-cycle done pulse, 16 bits of read data and a no-response flag.

Every frame is a sequence of bit slots. In each slot the management clock is low for `HALF_CYC` system cycles and then high for `HALF_CYC` system cycles. The data line changes only at the start of the low half. The PHY samples it on the rising edge, and the master samples it at the end of the high half. On a read the master checks the second turnaround slot. If the PHY has not pulled the line low, the master adds 32 recovery clocks and reports no response instead of data.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and while idle, `mdc` is 1, `mdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Slot numbering starts at 0. Slots 0..31 drive 1 (the preamble). Slots 32 and 33 drive 0 then 1. Slots 34 and 35 carry the opcode: 1,0 for a read and 0,1 for a write.
- R3: Slots 36..40 carry `req_phy`, MSB first. Slots 41..45 carry `req_reg`, MSB first.
- R4: Each slot is `HALF_CYC` cycles with `mdc` low followed by `HALF_CYC` cycles with `mdc` high. `mdio_o` changes only while `mdc` is low. `busy` stays high for exactly 2*`HALF_CYC`*(number of slots) cycles.
- R5: On a read, `mdio_oe` is 1 for slots 0..45 and 0 from slot 46 onward. `mdio_i` is sampled at the end of the high half of slot 47, and the PHY must drive 0 there.
- R6: On a read that gets a response, slots 48..63 are sampled at the end of their high halves and shifted into `rd_data` MSB first. One more slot (64) follows, so the frame has 65 rising edges of `mdc`, and `mdc` stays high afterwards.
- R7: If the slot-47 sample is 1, 32 more released slots follow (80 slots in total). The frame ends with `no_resp` = 1 and `rd_data` = 0.
- R8: On a write, slots 46 and 47 drive 1 then 0, and slots 48..63 drive `req_wdata` MSB first. Slot 64 is released (`mdio_oe` = 0), which gives 65 rising edges.
- R9: A `req_start` pulse while `busy` is high has no effect on the frame in progress.
- R10: `done` is a one-cycle pulse raised with `busy` low. `rd_data` and `no_resp` hold their values until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start request pulse |
| req_read | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Captured read data |
| no_resp | output | 1 | PHY did not pull the turnaround bit low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The assertions check on every cycle that the data line moves only while the clock is low, that the output enable is never set while idle, and that busy rises only after a start request. They also check that done is a lone pulse and that the result outputs hold still between frames. Slot contents, the position of the turnaround check, the 65- or 80-slot length, the exact busy duration and the shifting of read data can only be shown by the bench. It plays a PHY that answers or stays silent, records each slot on the rising clock edge and compares the result against frames it builds itself.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int HALF_CYC = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_start,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        no_resp,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [6:0] S_TA1 = 7'd46;
  localparam logic [6:0] S_TA2 = 7'd47;
  localparam logic [6:0] S_D0  = 7'd48;
  localparam logic [6:0] S_END = 7'd64;
  localparam logic [6:0] S_ERR = 7'd79;

  logic          busy_q, done_q, hi_q, rd_q, err_q;
  logic [DW-1:0] div_q;
  logic [6:0]    slot_q, k;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   wd_q, rdat_q;
  logic          bit_v;
  logic [6:0]    last_slot;

  assign last_slot = err_q ? S_ERR : S_END;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; hi_q <= 1'b0; rd_q <= 1'b0; err_q <= 1'b0;
      div_q <= '0; slot_q <= '0; phy_q <= '0; reg_q <= '0; wd_q <= '0; rdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_start) begin
          busy_q <= 1'b1;
          rd_q   <= req_read;
          phy_q  <= req_phy;
          reg_q  <= req_reg;
          wd_q   <= req_wdata;
          slot_q <= '0;
          hi_q   <= 1'b0;
          div_q  <= '0;
          rdat_q <= '0;
          err_q  <= 1'b0;
        end
      end else if (div_q == DW'(HALF_CYC - 1)) begin
        div_q <= '0;
        hi_q  <= ~hi_q;
        if (hi_q) begin
          if (rd_q && slot_q == S_TA2 && mdio_i) err_q <= 1'b1;
          if (rd_q && !err_q && slot_q >= S_D0 && slot_q < S_END)
            rdat_q <= {rdat_q[14:0], mdio_i};
          if (slot_q == last_slot) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 7'd1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  always_comb begin
    k     = '0;
    bit_v = 1'b0;
    if (slot_q < 7'd32)       bit_v = 1'b1;
    else if (slot_q == 7'd32) bit_v = 1'b0;
    else if (slot_q == 7'd33) bit_v = 1'b1;
    else if (slot_q == 7'd34) bit_v = rd_q;
    else if (slot_q == 7'd35) bit_v = ~rd_q;
    else if (slot_q <= 7'd40) begin
      k = 7'd40 - slot_q;
      bit_v = phy_q[k[2:0]];
    end else if (slot_q <= 7'd45) begin
      k = 7'd45 - slot_q;
      bit_v = reg_q[k[2:0]];
    end else if (slot_q == S_TA1) bit_v = 1'b1;
    else if (slot_q == S_TA2) bit_v = 1'b0;
    else if (slot_q < S_END) begin
      k = 7'd63 - slot_q;
      bit_v = wd_q[k[3:0]];
    end
  end

  assign mdio_oe = busy_q && (slot_q < S_TA1 || (!rd_q && slot_q < S_END));
  assign mdio_o  = mdio_oe & bit_v;
  assign mdc     = busy_q ? hi_q : 1'b1;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign no_resp = err_q;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));

  assert_change_low_R4: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> !mdc);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_start));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(rd_data) && $stable(no_resp)));
endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
  localparam int HALF = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 1'b0, req_read = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, no_resp, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int nchk = 0, nfail = 0, cyc = 0, rcount = 0;
  logic cap_o [0:95];
  logic cap_oe[0:95];
  logic m_ta_ok = 1'b1;
  logic [15:0] m_data = '0;

  mdio_frame_master #(.HALF_CYC(HALF)) i_mdio_frame_master (
    .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog R4: frame did not end, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  function automatic logic phy_resp(int s);
    if (s == 47) return m_ta_ok ? 1'b0 : 1'b1;
    if (s >= 48 && s < 64) return m_data[63 - s];
    return 1'b1;
  endfunction

  always @(negedge mdc) if (busy) mdio_i = phy_resp(rcount);
  always @(posedge mdc) if (busy) begin
    if (rcount < 96) begin cap_o[rcount] = mdio_o; cap_oe[rcount] = mdio_oe; end
    rcount++;
  end

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                           logic ta_ok, logic [15:0] pd, bit intrude);
    logic [63:0] ef;
    int nslot, bcnt, bad_bits, bad_oe, hdr;
    logic [15:0] hold_d;
    logic hold_e;
    m_ta_ok = ta_ok; m_data = pd; rcount = 0; mdio_i = 1'b1;
    @(negedge clk);
    req_read = rd; req_phy = pa; req_reg = ra; req_wdata = wd; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(rd_data == 16'h0 && no_resp == 1'b0, "R10", "cleared at start", {rd_data, no_resp}, 0);
    bcnt = 0;
    while (!done) begin
      if (busy) bcnt++;
      if (intrude && bcnt == 100) begin
        req_start = 1'b1; req_read = ~rd; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd;
      end else req_start = 1'b0;
      @(negedge clk);
    end
    req_start = 1'b0;
    nslot = (rd && !ta_ok) ? 80 : 65;
    ef = exp_frame(rd, pa, ra, wd);
    hdr = rd ? 46 : 64;
    bad_bits = 0; bad_oe = 0;
    for (int s = 0; s < nslot && s < 96; s++) begin
      logic eoe;
      eoe = (s < hdr);
      if (cap_oe[s] !== eoe) bad_oe++;
      if (eoe && cap_o[s] !== ef[63 - s]) bad_bits++;
    end
    check(bad_bits == 0, rd ? "R2/R3 read" : "R8", "slot bit mismatches", bad_bits, 0);
    check(bad_oe == 0, rd ? "R5" : "R8", "output enable mismatches", bad_oe, 0);
    check(rcount == nslot, rd ? (ta_ok ? "R6" : "R7") : "R8", "mdc rising edges", rcount, nslot);
    check(bcnt == 2 * HALF * nslot, "R4", "busy cycles", bcnt, 2 * HALF * nslot);
    check(!busy && mdc, "R6", "idle with mdc high at done", {busy, mdc}, 1);
    if (intrude) check(bad_bits == 0 && rcount == nslot, "R9", "start during busy ignored", bad_bits, 0);
    if (rd && ta_ok) check(rd_data == pd && !no_resp, "R6", "read data", rd_data, pd);
    if (rd && !ta_ok) check(no_resp && rd_data == 16'h0, "R7", "no response flag", {no_resp, rd_data}, 17'h10000);
    if (!rd) check(!no_resp, "R8", "no error on write", no_resp, 0);
    hold_d = rd_data; hold_e = no_resp;
    @(negedge clk);
    check(!done, "R10", "done single cycle", done, 0);
    repeat (20) @(negedge clk);
    check(rd_data == hold_d && no_resp == hold_e, "R10", "result held", rd_data, hold_d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mdc && !mdio_oe && !busy && !done, "R1", "reset idle state",
          {mdc, mdio_oe, busy, done}, 4'b1000);
    run_frame(1'b0, 5'h11, 5'h0A, 16'hA5C3, 1'b1, 16'h0, 1'b0);
    run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h8001, 1'b0);
    run_frame(1'b1, 5'h03, 5'h1E, 16'h0, 1'b0, 16'hFFFF, 1'b0);
    run_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b1, 16'h0, 1'b1);
    run_frame(1'b1, 5'h15, 5'h0B, 16'h0, 1'b1, 16'h0000, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic r, t;
      logic [4:0] p, g;
      logic [15:0] w, d;
      r = 1'($urandom); t = ($urandom % 4) != 0;
      p = 5'($urandom); g = 5'($urandom);
      w = 16'($urandom); d = 16'($urandom);
      run_frame(r, p, g, w, t, d, 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule